// File: doc/BRIEF.md
# DRAM Strobe Mode Decoder with Compressed Test

This block is a memory-side behavioural model of a multiplexed-address dynamic memory. On every rising clock it samples four active-low controls: row strobe, column strobe, write enable and output enable. From the order in which they move it classifies each row strobe cycle as a read, a write, a row-only refresh, a column-before-row refresh or a test-mode set. A small parameterised cell array sits behind this decode so that reads, writes and the compressed test behaviour can be seen at the pins.

A column-before-row cycle taken with write enable low sets a test flag. While the flag is set, the two lowest column address bits are ignored, and each data pin controls a group of four words. On a write, each pin's value goes into its own bit of all four words. On a read, each pin reports whether its four cells agree. An internal row counter advances on each refresh of the column-before-row kind that counts.

The data pins come as a separate input bus, an output bus and a drive-enable output, so that the block can sit inside a larger model or a bench.

Top module: `dtm_mode_decoder`

## Requirements
- R1: After reset, `dq_oe` is 0, `test_mode` is 0, `cycle_kind` is 0 and `refresh_row` is 0.
- R2: A row cycle with at least one column access reports `cycle_kind` 1 (read) if no write happened and 2 (write) if one did. The code appears on the edge where the row strobe is seen returning high.
- R3: A row cycle in which the column strobe never falls reports `cycle_kind` 3 (row-only refresh) when the row strobe returns high, and clears `test_mode`.
- R4: The row strobe falling while the column strobe is already low reports, on that edge, `cycle_kind` 4 when write enable is high and clears `test_mode`. With write enable low it reports 5 and sets `test_mode`.
- R5: `refresh_row` steps by one and wraps from ROWS-1 to 0. It steps on a code-4 cycle only outside test mode, and on every code-5 cycle. It changes at no other time.
- R6: `dq_oe` is 1 after an edge where a row cycle is open, a column access has occurred in it, the column strobe and output enable are low, and that column access was not an early write (write enable low when the column strobe fell). Otherwise it is 0.
- R7: Outside test mode, a driven `dq_out` holds the word at the latched row and the column latched at the latest column strobe fall. Each column fall inside one row cycle latches a new column. The value shown is the array content before any write taken on the same edge.
- R8: A write stores `dq_in` at the latched row and column. It is taken when write enable is low at the column fall (early write), or when write enable falls while the column strobe is low (delayed write or read-modify-write).
- R9: In test mode a write stores `dq_in` into all four words whose column differs only in the two lowest bits.
- R10: In test mode a driven `dq_out` bit p is 1 when bit p of those four words is equal in all of them, and 0 otherwise. The two lowest column bits do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | 1 | Column strobe, active low |
| wr_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data |
| dq_out | output | DQ_W | Read data or per-pin compare flags, 0 when not driven |
| dq_oe | output | 1 | Data pins driven |
| test_mode | output | 1 | Compressed test mode active |
| cycle_kind | output | 3 | Class of the last row cycle (codes in R2 to R4) |
| refresh_row | output | ROW_W | Internal refresh row counter |

## Verification
Refresh classes, `test_mode` and `refresh_row` are due on the first rising edge at which the row strobe is seen low. Read and write classes are due on the edge at which it is seen high again. `dq_oe` and `dq_out` follow the column fall or output enable change on the same edge. A write shows up in a read one edge later. The bench drives inputs and samples all outputs 1 ns after each rising edge. At every edge it compares against a behavioural model stepped at that edge, and it adds hand-computed checks on the values each requirement names.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
    typedef enum logic [2:0] {
        KIND_NONE     = 3'd0,
        KIND_READ     = 3'd1,
        KIND_WRITE    = 3'd2,
        KIND_ROWONLY  = 3'd3,
        KIND_COLFIRST = 3'd4,
        KIND_TESTSET  = 3'd5
    } kind_e;
endpackage

// File: rtl/dtm_level_hold.sv
// Registers the previous sampled level of the strobes for edge detection.
module dtm_level_hold #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] prev
);
    logic [N-1:0] prev_d, prev_q;

    always_comb prev_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;   // strobes idle high
        else        prev_q <= prev_d;
    end

    assign prev = prev_q;
endmodule

// File: rtl/dtm_cell_array.sv
// Small cell array with normal word access and compressed group access.
module dtm_cell_array #(
    parameter int ROWS = 4,
    parameter int COLS = 8,
    parameter int DQ_W = 4,
    parameter int GRP  = 4,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic             we,
    input  logic             tmode,
    input  logic [DQ_W-1:0]  wdata,
    output logic [DQ_W-1:0]  rdata
);
    localparam int WORDS = ROWS * COLS;

    typedef logic [WORDS-1:0][DQ_W-1:0] store_t;

    store_t                        mem_d, mem_q;
    logic [COL_W-1:0]              base;
    logic [DQ_W-1:0][GRP-1:0]      grp_bits;
    logic [DQ_W-1:0]               same;

    assign base = col & ~COL_W'(GRP - 1);

    // read side: depends on stored state only
    always_comb begin
        for (int p = 0; p < DQ_W; p++) begin
            for (int g = 0; g < GRP; g++) begin
                grp_bits[p][g] = mem_q[{row, base | COL_W'(g)}][p];
            end
            same[p] = (&grp_bits[p]) | ~(|grp_bits[p]);
        end
        rdata = tmode ? same : mem_q[{row, col}];
    end

    // write side
    always_comb begin
        mem_d = mem_q;
        if (we) begin
            if (tmode) begin
                for (int g = 0; g < GRP; g++) begin
                    mem_d[{row, base | COL_W'(g)}] = wdata;
                end
            end else begin
                mem_d[{row, col}] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    // R9: a compressed write leaves its group reading as all-equal next edge
    a_r9_group_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (we && tmode) |=> (mem_q[{$past(row), $past(base)}] == $past(wdata)));
endmodule

// File: rtl/dtm_mode_decoder.sv
module dtm_mode_decoder
    import dtm_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 8,
    parameter int DQ_W = 4,
    parameter int GRP  = 4,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int COL_W  = $clog2(COLS),
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_stb_n,
    input  logic              col_stb_n,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic              test_mode,
    output logic [2:0]        cycle_kind,
    output logic [ROW_W-1:0]  refresh_row
);
    typedef struct packed {
        logic             act;      // normal row cycle open
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             colseen;  // column access in this row cycle
        logic             early;    // current column access is an early write
        logic             wrote;    // a write happened in this row cycle
        logic             tmode;
        logic [ROW_W-1:0] rcnt;
        kind_e            kind;
        logic             dq_oe;
        logic [DQ_W-1:0]  dq_out;
    } state_t;

    state_t           d, q;
    logic [2:0]       prev_lvl;
    logic             row_fall, row_rise, col_fall, wr_fall;
    logic [COL_W-1:0] col_nxt;
    logic             arr_we;
    logic [DQ_W-1:0]  arr_rdata;
    logic [ROW_W-1:0] rcnt_nxt;

    dtm_level_hold #(.N(3)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({wr_n, col_stb_n, row_stb_n}),
        .prev  (prev_lvl)
    );

    assign row_fall = prev_lvl[0] & ~row_stb_n;
    assign row_rise = ~prev_lvl[0] & row_stb_n;
    assign col_fall = prev_lvl[1] & ~col_stb_n;
    assign wr_fall  = prev_lvl[2] & ~wr_n;
    assign rcnt_nxt = (q.rcnt == ROW_W'(ROWS - 1)) ? '0 : q.rcnt + 1'b1;

    // column latch select, kept apart so the array read has no loop
    always_comb begin
        col_nxt = q.col;
        if (q.act && !row_fall && !row_rise && col_fall) col_nxt = addr[COL_W-1:0];
    end

    dtm_cell_array #(
        .ROWS (ROWS),
        .COLS (COLS),
        .DQ_W (DQ_W),
        .GRP  (GRP)
    ) u_cells (
        .clk   (clk),
        .rst_n (rst_n),
        .row   (q.row),
        .col   (col_nxt),
        .we    (arr_we),
        .tmode (q.tmode),
        .wdata (dq_in),
        .rdata (arr_rdata)
    );

    always_comb begin
        d      = q;
        d.col  = col_nxt;
        arr_we = 1'b0;
        if (row_fall) begin
            if (!col_stb_n) begin
                d.act = 1'b0;
                if (!wr_n) begin
                    d.tmode = 1'b1;
                    d.rcnt  = rcnt_nxt;
                    d.kind  = KIND_TESTSET;
                end else begin
                    d.kind = KIND_COLFIRST;
                    if (q.tmode) d.tmode = 1'b0;
                    else         d.rcnt  = rcnt_nxt;
                end
            end else begin
                d.act     = 1'b1;
                d.row     = addr[ROW_W-1:0];
                d.colseen = 1'b0;
                d.early   = 1'b0;
                d.wrote   = 1'b0;
            end
        end else if (row_rise) begin
            if (q.act) begin
                if (!q.colseen) begin
                    d.kind  = KIND_ROWONLY;
                    d.tmode = 1'b0;
                end else if (q.wrote) begin
                    d.kind = KIND_WRITE;
                end else begin
                    d.kind = KIND_READ;
                end
            end
            d.act = 1'b0;
        end else if (q.act) begin
            if (col_fall) begin
                d.colseen = 1'b1;
                d.early   = ~wr_n;
                arr_we    = ~wr_n;
            end else if (!col_stb_n && wr_fall && q.colseen) begin
                arr_we = 1'b1;
            end
        end
        if (arr_we) d.wrote = 1'b1;
        d.dq_oe  = d.act && !col_stb_n && !oe_n && d.colseen && !d.early;
        d.dq_out = d.dq_oe ? arr_rdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.kind <= KIND_NONE;
        end else begin
            q <= d;
        end
    end

    assign dq_out      = q.dq_out;
    assign dq_oe       = q.dq_oe;
    assign test_mode   = q.tmode;
    assign cycle_kind  = q.kind;
    assign refresh_row = q.rcnt;

    // R4: column-first with write low enters test mode
    a_r4_tset_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (row_fall && !col_stb_n && !wr_n) |=> test_mode);
    // R4: column-first with write high leaves test mode
    a_r4_cbr_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (row_fall && !col_stb_n && wr_n) |=> !test_mode);
    // R5: counter only moves on a row strobe fall
    a_r5_counter_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !row_fall |=> $stable(refresh_row));
    // R5: column-first refresh inside test mode does not count
    a_r5_no_count_in_test: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && row_fall && !col_stb_n && wr_n) |=> $stable(refresh_row));
    // R6: idle row strobe releases the pins
    a_r6_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        row_stb_n |=> !dq_oe);
    // R6: early write never drives the pins
    a_r6_early_release: assert property (@(posedge clk) disable iff (!rst_n)
        (q.act && !row_stb_n && col_fall && !wr_n) |=> !dq_oe);
endmodule

// File: tb/test_dtm_mode_decoder.sv
`timescale 1ns/1ps
module test_dtm_mode_decoder;
    localparam int ROWS = 4;
    localparam int COLS = 8;
    localparam int DQW  = 4;
    localparam int GRP  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       row_stb_n = 1'b1, col_stb_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1;
    logic [2:0] addr = '0;
    logic [3:0] dq_in = '0;
    logic [3:0] dq_out;
    logic       dq_oe, test_mode;
    logic [2:0] cycle_kind;
    logic [1:0] refresh_row;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    dtm_mode_decoder i_dtm_mode_decoder (
        .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
        .wr_n(wr_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .test_mode(test_mode), .cycle_kind(cycle_kind),
        .refresh_row(refresh_row)
    );

    // behavioural reference model
    int m_mem [ROWS*COLS];
    bit m_act, m_seen, m_early, m_wrote, m_tm, m_oe;
    bit m_pr = 1, m_pc = 1, m_pw = 1;
    int m_row, m_col, m_cnt, m_kind, m_out;

    function automatic int model_read(int row, int col, bit tm);
        int base, res;
        if (!tm) return m_mem[row*COLS + col];
        base = (col / GRP) * GRP;
        res = 0;
        for (int p = 0; p < DQW; p++) begin
            int ones = 0;
            for (int g = 0; g < GRP; g++) ones += (m_mem[row*COLS + base + g] >> p) & 1;
            if (ones == 0 || ones == GRP) res |= (1 << p);
        end
        return res;
    endfunction

    task automatic model_step();
        bit rf, rr, cf, wf, tm_old;
        int wcol;
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_act = 0; m_seen = 0; m_early = 0; m_wrote = 0; m_tm = 0; m_oe = 0;
            m_pr = 1; m_pc = 1; m_pw = 1; m_row = 0; m_col = 0; m_cnt = 0;
            m_kind = 0; m_out = 0;
            return;
        end
        rf = m_pr && !row_stb_n;
        rr = !m_pr && row_stb_n;
        cf = m_pc && !col_stb_n;
        wf = m_pw && !wr_n;
        tm_old = m_tm;
        wcol = -1;
        if (rf) begin
            if (!col_stb_n) begin
                m_act = 0;
                if (!wr_n) begin
                    m_tm = 1; m_cnt = (m_cnt + 1) % ROWS; m_kind = 5;
                end else begin
                    m_kind = 4;
                    if (m_tm) m_tm = 0; else m_cnt = (m_cnt + 1) % ROWS;
                end
            end else begin
                m_act = 1; m_row = int'(addr) % ROWS; m_seen = 0; m_early = 0; m_wrote = 0;
            end
        end else if (rr) begin
            if (m_act) begin
                if (!m_seen) begin m_kind = 3; m_tm = 0; end
                else m_kind = m_wrote ? 2 : 1;
            end
            m_act = 0;
        end else if (m_act) begin
            if (cf) begin
                m_col = int'(addr) % COLS; m_seen = 1; m_early = !wr_n;
                if (!wr_n) wcol = m_col;
            end else if (!col_stb_n && wf && m_seen) begin
                wcol = m_col;
            end
        end
        if (wcol >= 0) m_wrote = 1;
        m_oe  = m_act && !col_stb_n && !oe_n && m_seen && !m_early;
        m_out = m_oe ? model_read(m_row, m_col, tm_old) : 0;
        if (wcol >= 0) begin
            if (tm_old) begin
                for (int g = 0; g < GRP; g++)
                    m_mem[m_row*COLS + (wcol / GRP) * GRP + g] = int'(dq_in);
            end else begin
                m_mem[m_row*COLS + wcol] = int'(dq_in);
            end
        end
        m_pr = row_stb_n; m_pc = col_stb_n; m_pw = wr_n;
    endtask

    task automatic check(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        string kreq;
        if (!rst_n) return;
        kreq = (m_kind == 0) ? "R1" : (m_kind <= 2) ? "R2" : (m_kind == 3) ? "R3" : "R4";
        check(kreq, "cycle_kind", int'(cycle_kind), m_kind);
        check("R4", "test_mode", int'(test_mode), int'(m_tm));
        check("R5", "refresh_row", int'(refresh_row), m_cnt);
        check("R6", "dq_oe", int'(dq_oe), int'(m_oe));
        check(m_tm ? "R10" : "R7", "dq_out", int'(dq_out), m_out);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        compare_all();
    endtask

    task automatic drive(bit r, bit c, bit w, bit o, int a, int dd);
        row_stb_n = r; col_stb_n = c; wr_n = w; oe_n = o;
        addr = 3'(a); dq_in = 4'(dd);
        tick();
    endtask

    task automatic wr_early(int row, int col, int data);
        drive(1, 1, 1, 1, 0, 0);
        drive(0, 1, 1, 1, row, 0);
        drive(0, 0, 0, 1, col, data);
        drive(0, 1, 1, 1, col, data);
        drive(1, 1, 1, 1, 0, 0);
    endtask

    task automatic wr_delayed(int row, int col, int data);
        drive(1, 1, 1, 1, 0, 0);
        drive(0, 1, 1, 1, row, 0);
        drive(0, 0, 1, 1, col, 0);
        drive(0, 0, 0, 1, col, data);
        drive(0, 1, 1, 1, col, data);
        drive(1, 1, 1, 1, 0, 0);
    endtask

    task automatic rd_word(int row, int col, output int val, output int oe);
        drive(1, 1, 1, 1, 0, 0);
        drive(0, 1, 1, 1, row, 0);
        drive(0, 0, 1, 0, col, 0);
        val = int'(dq_out); oe = int'(dq_oe);
        drive(0, 1, 1, 1, col, 0);
        drive(1, 1, 1, 1, 0, 0);
    endtask

    task automatic cyc_tset();
        drive(1, 0, 0, 1, 0, 0);
        drive(0, 0, 0, 1, 0, 0);
        drive(0, 0, 1, 1, 0, 0);
        drive(1, 1, 1, 1, 0, 0);
    endtask

    task automatic cyc_cbr();
        drive(1, 0, 1, 1, 0, 0);
        drive(0, 0, 1, 1, 0, 0);
        drive(1, 1, 1, 1, 0, 0);
    endtask

    task automatic cyc_ror(int row);
        drive(1, 1, 1, 1, 0, 0);
        drive(0, 1, 1, 1, row, 0);
        drive(1, 1, 1, 1, 0, 0);
    endtask

    bit done = 0;

    initial begin
        int v, e;
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        check("R1", "reset dq_oe", int'(dq_oe), 0);
        check("R1", "reset test_mode", int'(test_mode), 0);
        check("R1", "reset cycle_kind", int'(cycle_kind), 0);
        check("R1", "reset refresh_row", int'(refresh_row), 0);

        wr_early(0, 0, 'hA);
        check("R2", "kind after write", int'(cycle_kind), 2);
        wr_early(1, 5, 'h3);
        wr_early(3, 7, 'hC);
        rd_word(0, 0, v, e);
        check("R7", "read (0,0)", v, 'hA);
        check("R6", "read drives", e, 1);
        check("R2", "kind after read", int'(cycle_kind), 1);
        rd_word(1, 5, v, e);
        check("R8", "early write (1,5)", v, 'h3);

        wr_delayed(2, 1, 'h6);
        rd_word(2, 1, v, e);
        check("R8", "delayed write (2,1)", v, 'h6);

        // early write with output enable low: pins stay released
        drive(1, 1, 1, 1, 0, 0);
        drive(0, 1, 1, 1, 0, 0);
        drive(0, 0, 0, 0, 2, 'h5);
        check("R6", "early write no drive", int'(dq_oe), 0);
        drive(0, 1, 1, 1, 0, 0);
        drive(1, 1, 1, 1, 0, 0);

        // fast page: two columns in one row cycle
        drive(1, 1, 1, 1, 0, 0);
        drive(0, 1, 1, 1, 0, 0);
        drive(0, 0, 1, 0, 0, 0);
        check("R7", "page col0", int'(dq_out), 'hA);
        drive(0, 1, 1, 0, 0, 0);
        check("R6", "column high releases", int'(dq_oe), 0);
        drive(0, 0, 1, 0, 2, 0);
        check("R7", "page col2", int'(dq_out), 'h5);
        drive(0, 1, 1, 1, 0, 0);
        drive(1, 1, 1, 1, 0, 0);

        // read-modify-write at (1,5)
        drive(1, 1, 1, 1, 0, 0);
        drive(0, 1, 1, 1, 1, 0);
        drive(0, 0, 1, 0, 5, 0);
        check("R7", "rmw read", int'(dq_out), 'h3);
        drive(0, 0, 0, 0, 5, 'h7);
        check("R7", "rmw old data on write edge", int'(dq_out), 'h3);
        drive(0, 0, 0, 0, 5, 'h7);
        check("R8", "rmw new data", int'(dq_out), 'h7);
        drive(0, 1, 1, 1, 0, 0);
        drive(1, 1, 1, 1, 0, 0);
        check("R2", "kind after rmw", int'(cycle_kind), 2);

        cyc_ror(2);
        check("R3", "row-only kind", int'(cycle_kind), 3);

        cyc_cbr(); check("R5", "cbr count 1", int'(refresh_row), 1);
        check("R4", "cbr kind", int'(cycle_kind), 4);
        cyc_cbr(); check("R5", "cbr count 2", int'(refresh_row), 2);
        cyc_cbr(); check("R5", "cbr count 3", int'(refresh_row), 3);
        cyc_cbr(); check("R5", "cbr wrap", int'(refresh_row), 0);

        cyc_tset();
        check("R4", "tset enters", int'(test_mode), 1);
        check("R4", "tset kind", int'(cycle_kind), 5);
        check("R5", "tset counts", int'(refresh_row), 1);
        cyc_cbr();
        check("R4", "cbr exits test", int'(test_mode), 0);
        check("R5", "cbr in test no count", int'(refresh_row), 1);

        cyc_tset();
        check("R5", "tset counts again", int'(refresh_row), 2);
        wr_early(1, 4, 'h9);
        rd_word(1, 6, v, e);
        check("R10", "compressed all equal", v, 'hF);
        cyc_ror(0);
        check("R3", "row-only exits test", int'(test_mode), 0);
        rd_word(1, 7, v, e);
        check("R9", "group word 7", v, 'h9);
        rd_word(1, 4, v, e);
        check("R9", "group word 4", v, 'h9);
        rd_word(1, 5, v, e);
        check("R9", "group word 5", v, 'h9);

        wr_early(3, 2, 'h1);
        cyc_tset();
        rd_word(3, 0, v, e);
        check("R10", "compressed mismatch bit0", v, 'hE);
        rd_word(3, 3, v, e);
        check("R10", "low column bits ignored", v, 'hE);
        cyc_cbr();
        check("R5", "exit count unchanged", int'(refresh_row), 3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule